// File: doc/BRIEF.md
# Dual-Mode Stack Pointer Unit

This block keeps the stack pointer state of a small 8-bit processor core and turns push and pop strobes into stack addresses. It works in one of two modes. In the narrow mode the stack is an 8-bit pointer into the internal scratchpad RAM and wraps within 256 bytes. In the wide mode the stack spans up to 1 KB of internal extended data memory. The wide address takes its two upper bits from a separate extension register and its lower eight bits from the ordinary pointer.

The core drives single-cycle push and pop strobes and direct register writes, and it reads the pointer, the extension register and the mode bit back from output ports. Within the same cycle the block presents the address for the current stack access on `addr_o`, together with `tgt_ext_o`, which tells the memory side whether that address goes to the scratchpad or to extended data memory. A push uses the incremented pointer as its address. A pop uses the current pointer and decrements it afterwards.

Top module: `dual_stack_ptr`

## Requirements
- R1: While reset is asserted and after it is released, the pointer reads 07h, the extension register reads 00h and the mode bit reads 0 (narrow mode).
- R2: In narrow mode (mode 0), `tgt_ext_o` is 0 and `addr_o` is the 8-bit address with bits 9:8 equal to zero.
- R3: In wide mode (mode 1), `tgt_ext_o` is 1 and `addr_o` is {extension bits 1:0, pointer bits 7:0}.
- R4: A push (`push_i`=1, `pop_i`=0, `wr_en_i`=0) puts the incremented pointer on `addr_o` in the same cycle and stores it at the next clock edge.
- R5: A pop (`pop_i`=1, `push_i`=0, `wr_en_i`=0) puts the current pointer on `addr_o` and stores the pointer minus one at the next clock edge.
- R6: In narrow mode the pointer wraps modulo 256 in both directions (FFh+1 gives 00h, 00h-1 gives FFh), and push and pop leave the extension register unchanged.
- R7: In wide mode push and pop act on the 10-bit value {extension, pointer}, so a carry or borrow passes into the extension bits and the value wraps modulo 1024 (3FFh+1 gives 000h).
- R8: A write to the extension register keeps only data bits 1:0, and bits 7:2 of `esp_o` always read zero.
- R9: `wr_sel_i` picks the register to write: 00 is the pointer, 01 is the extension register, 10 is the mode bit (data bit 0), and 11 writes nothing. The write takes effect at the next clock edge.
- R10: When `wr_en_i` is 1, any push or pop in the same cycle is dropped: no pointer change, and `addr_o` shows the current pointer.
- R11: When push and pop arrive in the same cycle without a write, both are dropped: the registers keep their values and `addr_o` shows the current pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push strobe from the core |
| pop_i | input | 1 | Pop strobe from the core |
| wr_en_i | input | 1 | Direct register write enable |
| wr_sel_i | input | 2 | Write target: 00 pointer, 01 extension, 10 mode, 11 none |
| wr_data_i | input | 8 | Write data |
| sp_o | output | 8 | Current stack pointer |
| esp_o | output | 8 | Extension register, bits 7:2 read zero |
| mode_o | output | 1 | Stack mode: 0 narrow, 1 wide |
| addr_o | output | 10 | Stack address for the current access |
| tgt_ext_o | output | 1 | 1 selects extended data memory, 0 the scratchpad |

## Verification
The risky overlaps are a register write landing in the same cycle as a push or pop, and a push and a pop arriving together. The bench drives both cases on purpose in each mode. It also drives them again from a random mix of strobes and writes that includes writes to the mode bit itself. On every clock it compares all five outputs against a behavioural model that holds the pointer as a plain integer and applies the R10 and R11 precedence rules. A design that lets a push through beside a write, or that lets a push and a pop cancel in the wrong way, shows a pointer or address difference in the next cycle.

// File: rtl/spu_pkg.sv
package spu_pkg;

   typedef enum logic [1:0] {
      SEL_PTR  = 2'b00,
      SEL_XTN  = 2'b01,
      SEL_MODE = 2'b10,
      SEL_NONE = 2'b11
   } wsel_e;

   typedef enum logic {
      MODE_NARROW = 1'b0,
      MODE_WIDE   = 1'b1
   } smode_e;

endpackage

// File: rtl/spu_mode_reg.sv
module spu_mode_reg
   import spu_pkg::*;
(
   input  logic   clk_i,
   input  logic   rst_ni,
   input  logic   wr_hit_i,
   input  logic   wr_bit_i,
   output smode_e mode_o
);

   smode_e mode_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_q <= MODE_NARROW;
      end else if (wr_hit_i) begin
         mode_q <= smode_e'(wr_bit_i);
      end
   end

   assign mode_o = mode_q;

endmodule

// File: rtl/spu_ptr_core.sv
module spu_ptr_core
   import spu_pkg::*;
#(
   parameter int unsigned SP_W   = 8,
   parameter int unsigned EXT_W  = 2,
   parameter int unsigned REG_W  = 8,
   parameter logic [SP_W-1:0] SP_RST = 8'h07,
   localparam int unsigned AW = SP_W + EXT_W
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  smode_e           mode_i,
   input  logic             push_i,
   input  logic             pop_i,
   input  logic             wr_en_i,
   input  wsel_e            wr_sel_i,
   input  logic [REG_W-1:0] wr_data_i,
   output logic [SP_W-1:0]  sp_o,
   output logic [EXT_W-1:0] ext_o,
   output logic [AW-1:0]    src_o
);

   logic [SP_W-1:0]  sp_q, sp_d;
   logic [EXT_W-1:0] ext_q, ext_d;
   logic [AW-1:0]    full_cur, full_up, full_dn;
   logic [SP_W-1:0]  sp_up, sp_dn;
   logic             do_push, do_pop;

   // writes beat strobes; simultaneous push and pop cancel
   assign do_push = push_i & ~pop_i & ~wr_en_i;
   assign do_pop  = pop_i & ~push_i & ~wr_en_i;

   assign full_cur = {ext_q, sp_q};
   assign full_up  = full_cur + AW'(1);
   assign full_dn  = full_cur - AW'(1);
   assign sp_up    = sp_q + SP_W'(1);
   assign sp_dn    = sp_q - SP_W'(1);

   always_comb begin
      sp_d  = sp_q;
      ext_d = ext_q;
      if (wr_en_i) begin
         unique case (wr_sel_i)
            SEL_PTR:  sp_d  = wr_data_i[SP_W-1:0];
            SEL_XTN:  ext_d = wr_data_i[EXT_W-1:0];
            default: ;
         endcase
      end else if (do_push) begin
         if (mode_i == MODE_WIDE) begin
            {ext_d, sp_d} = full_up;
         end else begin
            sp_d = sp_up;
         end
      end else if (do_pop) begin
         if (mode_i == MODE_WIDE) begin
            {ext_d, sp_d} = full_dn;
         end else begin
            sp_d = sp_dn;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sp_q  <= SP_RST;
         ext_q <= '0;
      end else begin
         sp_q  <= sp_d;
         ext_q <= ext_d;
      end
   end

   // address source: pre-increment for push, current value otherwise
   always_comb begin
      src_o = full_cur;
      if (do_push) begin
         src_o = (mode_i == MODE_WIDE) ? full_up : {ext_q, sp_up};
      end
   end

   assign sp_o  = sp_q;
   assign ext_o = ext_q;

endmodule

// File: rtl/spu_addr_fmt.sv
module spu_addr_fmt
   import spu_pkg::*;
#(
   parameter int unsigned SP_W  = 8,
   parameter int unsigned EXT_W = 2,
   parameter int unsigned REG_W = 8,
   localparam int unsigned AW = SP_W + EXT_W
) (
   input  smode_e           mode_i,
   input  logic [AW-1:0]    src_i,
   input  logic [EXT_W-1:0] ext_i,
   output logic [AW-1:0]    addr_o,
   output logic             tgt_ext_o,
   output logic [REG_W-1:0] ext_view_o
);

   logic wide;
   assign wide = (mode_i == MODE_WIDE);

   assign addr_o[SP_W-1:0] = src_i[SP_W-1:0];
   assign tgt_ext_o        = wide;

   for (genvar b = SP_W; b < AW; b++) begin : g_hi
      assign addr_o[b] = wide & src_i[b];
   end

   for (genvar r = 0; r < REG_W; r++) begin : g_view
      if (r < EXT_W) begin : g_live
         assign ext_view_o[r] = ext_i[r];
      end else begin : g_zero
         assign ext_view_o[r] = 1'b0;
      end
   end

endmodule

// File: rtl/dual_stack_ptr.sv
module dual_stack_ptr
   import spu_pkg::*;
#(
   parameter int unsigned SP_W   = 8,
   parameter int unsigned EXT_W  = 2,
   parameter int unsigned REG_W  = 8,
   parameter logic [SP_W-1:0] SP_RST = 8'h07,
   localparam int unsigned AW = SP_W + EXT_W
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             push_i,
   input  logic             pop_i,
   input  logic             wr_en_i,
   input  logic [1:0]       wr_sel_i,
   input  logic [REG_W-1:0] wr_data_i,
   output logic [SP_W-1:0]  sp_o,
   output logic [REG_W-1:0] esp_o,
   output logic             mode_o,
   output logic [AW-1:0]    addr_o,
   output logic             tgt_ext_o
);

   initial begin
      if (SP_W < 2 || SP_W > 16) $error("SP_W out of range");
      if (EXT_W < 1 || EXT_W > 8) $error("EXT_W out of range");
      if (REG_W < SP_W) $error("REG_W narrower than pointer");
      if (REG_W <= EXT_W) $error("REG_W must exceed EXT_W");
   end

   smode_e           mode;
   wsel_e            wsel;
   logic [EXT_W-1:0] ext;
   logic [AW-1:0]    src;

   assign wsel = wsel_e'(wr_sel_i);

   spu_mode_reg u_mode (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_hit_i (wr_en_i && (wsel == SEL_MODE)),
      .wr_bit_i (wr_data_i[0]),
      .mode_o   (mode)
   );

   spu_ptr_core #(
      .SP_W(SP_W), .EXT_W(EXT_W), .REG_W(REG_W), .SP_RST(SP_RST)
   ) u_core (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mode_i    (mode),
      .push_i    (push_i),
      .pop_i     (pop_i),
      .wr_en_i   (wr_en_i),
      .wr_sel_i  (wsel),
      .wr_data_i (wr_data_i),
      .sp_o      (sp_o),
      .ext_o     (ext),
      .src_o     (src)
   );

   spu_addr_fmt #(
      .SP_W(SP_W), .EXT_W(EXT_W), .REG_W(REG_W)
   ) u_fmt (
      .mode_i     (mode),
      .src_i      (src),
      .ext_i      (ext),
      .addr_o     (addr_o),
      .tgt_ext_o  (tgt_ext_o),
      .ext_view_o (esp_o)
   );

   assign mode_o = (mode == MODE_WIDE);

endmodule

// File: rtl/spu_chk.sv
module spu_chk #(
   parameter int unsigned SP_W  = 8,
   parameter int unsigned EXT_W = 2,
   parameter int unsigned REG_W = 8,
   localparam int unsigned AW = SP_W + EXT_W
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             push_i,
   input logic             pop_i,
   input logic             wr_en_i,
   input logic [1:0]       wr_sel_i,
   input logic [REG_W-1:0] wr_data_i,
   input logic [SP_W-1:0]  sp_o,
   input logic [REG_W-1:0] esp_o,
   input logic             mode_o,
   input logic [AW-1:0]    addr_o,
   input logic             tgt_ext_o
);

   logic lone_push, lone_pop;
   assign lone_push = push_i && !pop_i && !wr_en_i;
   assign lone_pop  = pop_i && !push_i && !wr_en_i;

   a_r2_narrow_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mode_o |-> (!tgt_ext_o && addr_o[AW-1:SP_W] == '0));

   a_r3_wide_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o && !lone_push) |-> (tgt_ext_o && addr_o == {esp_o[EXT_W-1:0], sp_o}));

   a_r4_push_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lone_push && !mode_o) |-> addr_o[SP_W-1:0] == SP_W'(sp_o + SP_W'(1)));

   a_r5_pop_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lone_pop && !mode_o) |=> sp_o == SP_W'($past(sp_o) - SP_W'(1)));

   a_r6_ext_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mode_o && !wr_en_i) |=> $stable(esp_o));

   a_r8_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      esp_o[REG_W-1:EXT_W] == '0);

   a_r9_ptr_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_sel_i == 2'b00) |=> sp_o == $past(wr_data_i[SP_W-1:0]));

   a_r11_both_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push_i && pop_i && !wr_en_i) |=> ($stable(sp_o) && $stable(esp_o)));

endmodule

bind dual_stack_ptr spu_chk #(.SP_W(SP_W), .EXT_W(EXT_W), .REG_W(REG_W)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push_i), .pop_i(pop_i),
   .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
   .sp_o(sp_o), .esp_o(esp_o), .mode_o(mode_o), .addr_o(addr_o),
   .tgt_ext_o(tgt_ext_o)
);

// File: tb/dual_stack_ptr_tb.sv
module dual_stack_ptr_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       push = 1'b0, pop = 1'b0, wen = 1'b0;
   logic [1:0] sel = 2'b11;
   logic [7:0] wdat = 8'h00;
   logic [7:0] sp, esp;
   logic       mode, tgt;
   logic [9:0] addr;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   int m_sp, m_ext, m_mode;

   always #10 clk = ~clk;

   dual_stack_ptr dut_i (
      .clk_i(clk), .rst_ni(rst_n), .push_i(push), .pop_i(pop),
      .wr_en_i(wen), .wr_sel_i(sel), .wr_data_i(wdat),
      .sp_o(sp), .esp_o(esp), .mode_o(mode), .addr_o(addr), .tgt_ext_o(tgt)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic compare_all(input string req);
      int full, a;
      bit lp;
      lp   = push && !pop && !wen;
      full = m_ext * 256 + m_sp;
      if (m_mode == 1) a = lp ? (full + 1) % 1024 : full;
      else             a = lp ? (m_sp + 1) % 256 : m_sp;
      chk(req, "sp", int'(sp), m_sp);
      chk(req, "esp", int'(esp), m_ext);
      chk(req, "mode", int'(mode), m_mode);
      chk(req, "addr", int'(addr), a);
      chk(req, "tgt", int'(tgt), m_mode);
   endtask

   task automatic model_edge();
      int full;
      full = m_ext * 256 + m_sp;
      if (wen) begin
         case (sel)
            2'b00: m_sp = int'(wdat);
            2'b01: m_ext = int'(wdat) % 4;
            2'b10: m_mode = int'(wdat) % 2;
            default: ;
         endcase
      end else if (push && !pop) begin
         if (m_mode == 1) begin
            full = (full + 1) % 1024; m_ext = full / 256; m_sp = full % 256;
         end else m_sp = (m_sp + 1) % 256;
      end else if (pop && !push) begin
         if (m_mode == 1) begin
            full = (full + 1023) % 1024; m_ext = full / 256; m_sp = full % 256;
         end else m_sp = (m_sp + 255) % 256;
      end
   endtask

   task automatic step(input bit pu, input bit po, input bit we,
                       input logic [1:0] s, input logic [7:0] d, input string req);
      @(negedge clk);
      push = pu; pop = po; wen = we; sel = s; wdat = d;
      #5;
      compare_all(req);
      @(posedge clk);
      model_edge();
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      m_sp = 7; m_ext = 0; m_mode = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      compare_all("R1");             // values held in reset
      rst_n = 1'b1;
      #2 compare_all("R1");
      // narrow pushes and pops
      step(1, 0, 0, 2'b11, 8'h00, "R4");
      step(1, 0, 0, 2'b11, 8'h00, "R2");
      step(0, 0, 0, 2'b11, 8'h00, "R4");
      step(0, 1, 0, 2'b11, 8'h00, "R5");
      step(0, 1, 0, 2'b11, 8'h00, "R5");
      // narrow wrap both ways, extension kept
      step(0, 0, 1, 2'b01, 8'hFE, "R8");
      step(0, 0, 1, 2'b00, 8'hFE, "R9");
      step(1, 0, 0, 2'b11, 8'h00, "R6");
      step(1, 0, 0, 2'b11, 8'h00, "R6");
      step(0, 1, 0, 2'b11, 8'h00, "R6");
      step(0, 1, 0, 2'b11, 8'h00, "R6");
      step(0, 0, 0, 2'b11, 8'h00, "R6");
      // select 11 writes nothing
      step(0, 0, 1, 2'b11, 8'h55, "R9");
      step(0, 0, 0, 2'b11, 8'h00, "R9");
      // switch to wide mode
      step(0, 0, 1, 2'b10, 8'h01, "R9");
      step(0, 0, 1, 2'b01, 8'h00, "R3");
      step(0, 0, 1, 2'b00, 8'hFF, "R3");
      step(1, 0, 0, 2'b11, 8'h00, "R7");   // 0FF -> 100
      step(0, 1, 0, 2'b11, 8'h00, "R7");   // back to 0FF
      step(0, 1, 0, 2'b11, 8'h00, "R7");
      step(0, 0, 1, 2'b01, 8'h03, "R7");
      step(0, 0, 1, 2'b00, 8'hFF, "R7");
      step(1, 0, 0, 2'b11, 8'h00, "R7");   // 3FF -> 000
      step(0, 1, 0, 2'b11, 8'h00, "R7");   // 000 -> 3FF
      step(0, 0, 0, 2'b11, 8'h00, "R3");
      // collisions
      step(1, 1, 0, 2'b11, 8'h00, "R11");
      step(1, 0, 1, 2'b00, 8'h40, "R10");
      step(0, 1, 1, 2'b01, 8'h02, "R10");
      step(1, 0, 1, 2'b10, 8'h00, "R10");
      step(1, 1, 0, 2'b11, 8'h00, "R11");
      step(0, 0, 0, 2'b11, 8'h00, "R2");
      // random mix
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = $urandom % 16;
         step(r[0] == 1'b1, r[1] == 1'b1, (r % 7) == 0, 2'($urandom), 8'($urandom), "R10");
      end
      done = 1;
      @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule